// File: doc/BRIEF.md
# Read-Compute/Write Compute-in-Memory Bank

This block is a digital compute-in-memory bank. It stores a small array of signed weight rows and forms a 32-lane dot product between one stored row and a signed 8-bit activation vector. The 32 products are summed by an adder tree into a single 21-bit signed result. Each operation runs in two phases, and the second phase does two things at once. In phase one the addressed row is read out and captured in the registers that feed the adder tree. In phase two the tree evaluates from that captured copy, and in the same cycle an optional new row is written into the array. Reloading weights therefore takes no cycles of its own beyond the compute.

A one-cycle `start` pulse submits an operation. With it come the read row, the activation vector, the precision mode, and an optional write (row address and data). `busy` covers both phases. The row select stays on the read row for the whole operation. `out_valid` pulses once when the sum lands in its output register. A `start` that arrives while the bank is busy is dropped and sets a sticky `overrun` flag, which stays set until `ovr_clr` is asserted.

Top module: `cim_rcw_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `busy`, `out_valid`, `overrun`, `row_sel` and `sum_out` are all zero.
- R2: A `start` accepted in idle makes `busy` high for exactly the two following cycles. `out_valid` is high only in the cycle after that, for exactly one cycle, and `sum_out` keeps its value in every cycle without `out_valid`.
- R3: In INT8 mode (`mode_i4`=0), the weight of lane i is byte i of the row (bits 8i+7..8i) as a signed value. `sum_out` equals the sum over the 32 lanes of weight times signed activation byte i, with no overflow across the full range (from -520192 to +524288).
- R4: In INT4 mode (`mode_i4`=1), the weight of lane i is the sign-extended 4-bit field at bits 4i+3..4i. Byte k therefore holds lane 2k in its lower nibble and lane 2k+1 in its upper nibble. Row bits 255..128 have no effect on the sum.
- R5: A write submitted with an operation (`wr_en`=1) stores `wr_data` into row `wr_row` during phase two, and the next operation that reads that row uses the new data.
- R6: When the write row equals the read row of the same operation, the sum uses the row contents from before the write.
- R7: During both phases `row_sel` is one-hot on the read row and does not change between them. In idle it is zero.
- R8: A `start` while `busy` is high starts no operation, produces no extra `out_valid`, and leaves the running operation's sum unchanged. In the next cycle `overrun` is high.
- R9: `overrun` stays high until a cycle with `ovr_clr`=1 and no dropped start, after which it is low. If a dropped start and `ovr_clr` fall in the same cycle, `overrun` ends up high.
- R10: Reset clears every weight row to zero, so an operation on a row never written returns a sum of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Submit an operation (one-cycle pulse) |
| mode_i4 | input | 1 | Precision: 0 INT8 weights, 1 INT4 weights |
| rd_row | input | 3 | Row read in phase one |
| act_vec | input | 256 | 32 signed 8-bit activations, lane i at bits 8i+7..8i |
| wr_en | input | 1 | Write a row during phase two of this operation |
| wr_row | input | 3 | Row written in phase two |
| wr_data | input | 256 | Row data written in phase two |
| ovr_clr | input | 1 | Clear the sticky overrun flag |
| busy | output | 1 | Operation in progress (both phases) |
| row_sel | output | 8 | One-hot row select, held across both phases |
| sum_out | output | 21 | Registered signed dot-product result |
| out_valid | output | 1 | One-cycle pulse when `sum_out` is updated |
| overrun | output | 1 | Sticky flag: a start was dropped while busy |

## Verification
The dot product is tried with hashed pseudo-random rows and activation vectors in both modes on every row. These runs separate a correct lane-to-byte mapping from swapped or shifted lanes, and a correct INT4 nibble order from a reversed one. A full sweep of all sixteen 4-bit weight codes against the activation extremes, together with all-minimum and all-maximum INT8 rows, tells proper sign extension and a wide enough sum apart from zero-extension or truncation. A write to the same row as the read tells a compute taken from the latched copy apart from one that sees the new data. Starts issued in the middle of an operation, with a changed activation vector and with a clear in the same cycle, show whether the drop and the flag priority are handled.

// File: rtl/cim_pkg.sv
package cim_pkg;

    localparam int unsigned CIM_WB    = 8;
    localparam int unsigned CIM_NIB   = CIM_WB / 2;
    localparam int unsigned CIM_ACT_W = 8;

    typedef enum logic {
        PREC_INT8 = 1'b0,
        PREC_INT4 = 1'b1
    } prec_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_READ = 2'd1,
        PH_COMP = 2'd2
    } phase_e;

    function automatic logic signed [CIM_WB-1:0] sext_nib(input logic [CIM_NIB-1:0] n);
        return {{(CIM_WB-CIM_NIB){n[CIM_NIB-1]}}, n};
    endfunction

    function automatic logic signed [CIM_WB-1:0] lane_weight(
        input logic [CIM_WB-1:0]  full_byte,
        input logic [CIM_NIB-1:0] nib,
        input prec_e              prec
    );
        if (prec == PREC_INT4) begin
            return sext_nib(nib);
        end
        return full_byte;
    endfunction

endpackage

// File: rtl/cim_weight_array.sv
module cim_weight_array #(
    parameter int unsigned ROWS  = 8,
    parameter int unsigned ROW_W = 256,
    parameter int unsigned AW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_addr,
    output logic [ROW_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [ROW_W-1:0] wr_data
);

    logic [ROW_W-1:0] mem [ROWS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < int'(ROWS); r++) begin
                mem[r] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cim_mac_tree.sv
module cim_mac_tree
    import cim_pkg::*;
#(
    parameter int unsigned LANES = 32,
    parameter int unsigned ACT_W = 8,
    localparam int unsigned ROW_W  = LANES * CIM_WB,
    localparam int unsigned PROD_W = CIM_WB + ACT_W,
    localparam int unsigned SUM_W  = PROD_W + $clog2(LANES)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lat_en,
    input  logic [ROW_W-1:0]         row_in,
    input  logic                     sum_en,
    input  logic [LANES*ACT_W-1:0]   act_vec,
    input  prec_e                    prec,
    output logic signed [SUM_W-1:0]  sum_q
);

    logic [ROW_W-1:0]          w_lat;
    logic signed [SUM_W-1:0]   leaf [LANES];
    logic signed [SUM_W-1:0]   node [1:2*LANES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            w_lat <= '0;
        end else if (lat_en) begin
            w_lat <= row_in;
        end
    end

    for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
        logic signed [CIM_WB-1:0] w_i;
        logic signed [ACT_W-1:0]  a_i;
        logic signed [PROD_W-1:0] p_i;

        assign w_i = lane_weight(w_lat[i*CIM_WB +: CIM_WB],
                                 w_lat[i*CIM_NIB +: CIM_NIB], prec);
        assign a_i = act_vec[i*ACT_W +: ACT_W];
        assign p_i = w_i * a_i;
        assign leaf[i] = {{(SUM_W-PROD_W){p_i[PROD_W-1]}}, p_i};
    end

    always_comb begin
        for (int i = 0; i < int'(LANES); i++) begin
            node[int'(LANES) + i] = leaf[i];
        end
        for (int k = int'(LANES) - 1; k >= 1; k--) begin
            node[k] = node[2*k] + node[2*k+1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
        end else if (sum_en) begin
            sum_q <= node[1];
        end
    end

endmodule

// File: rtl/cim_seq_ctrl.sv
module cim_seq_ctrl
    import cim_pkg::*;
#(
    parameter int unsigned ROWS = 8,
    parameter int unsigned AW   = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            ovr_clr,
    input  logic [AW-1:0]   rd_row,
    output logic            accept,
    output logic            lat_en,
    output logic            cmp_en,
    output logic [AW-1:0]   cur_row,
    output logic            busy,
    output logic [ROWS-1:0] row_sel,
    output logic            out_valid,
    output logic            overrun
);

    phase_e        st_q;
    logic [AW-1:0] row_q;
    logic          vld_q;
    logic          ovr_q;

    assign busy    = (st_q != PH_IDLE);
    assign accept  = start && (st_q == PH_IDLE);
    assign lat_en  = (st_q == PH_READ);
    assign cmp_en  = (st_q == PH_COMP);
    assign cur_row = row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_IDLE;
            row_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= cmp_en;
            unique case (st_q)
                PH_IDLE: if (accept) begin
                    st_q  <= PH_READ;
                    row_q <= rd_row;
                end
                PH_READ: st_q <= PH_COMP;
                PH_COMP: st_q <= PH_IDLE;
                default: st_q <= PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else if (start && busy) begin
            ovr_q <= 1'b1;
        end else if (ovr_clr) begin
            ovr_q <= 1'b0;
        end
    end

    for (genvar r = 0; r < int'(ROWS); r++) begin : g_wl
        assign row_sel[r] = busy && (row_q == AW'(r));
    end

    assign out_valid = vld_q;
    assign overrun   = ovr_q;

endmodule

// File: rtl/cim_rcw_bank.sv
module cim_rcw_bank
    import cim_pkg::*;
#(
    parameter int unsigned LANES = 32,
    parameter int unsigned ROWS  = 8,
    parameter int unsigned ACT_W = CIM_ACT_W,
    localparam int unsigned AW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int unsigned ROW_W = LANES * CIM_WB,
    localparam int unsigned SUM_W = CIM_WB + ACT_W + $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    mode_i4,
    input  logic [AW-1:0]           rd_row,
    input  logic [LANES*ACT_W-1:0]  act_vec,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_row,
    input  logic [ROW_W-1:0]        wr_data,
    input  logic                    ovr_clr,
    output logic                    busy,
    output logic [ROWS-1:0]         row_sel,
    output logic signed [SUM_W-1:0] sum_out,
    output logic                    out_valid,
    output logic                    overrun
);

    typedef struct packed {
        prec_e                   prec;
        logic                    wr_en;
        logic [AW-1:0]           wr_row;
        logic [ROW_W-1:0]        wr_data;
        logic [LANES*ACT_W-1:0]  act;
    } op_t;

    op_t              op_q;
    logic             accept;
    logic             lat_en;
    logic             cmp_en;
    logic [AW-1:0]    cur_row;
    logic [ROW_W-1:0] rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q <= '0;
        end else if (accept) begin
            op_q.prec    <= prec_e'(mode_i4);
            op_q.wr_en   <= wr_en;
            op_q.wr_row  <= wr_row;
            op_q.wr_data <= wr_data;
            op_q.act     <= act_vec;
        end
    end

    cim_seq_ctrl #(
        .ROWS (ROWS),
        .AW   (AW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ovr_clr   (ovr_clr),
        .rd_row    (rd_row),
        .accept    (accept),
        .lat_en    (lat_en),
        .cmp_en    (cmp_en),
        .cur_row   (cur_row),
        .busy      (busy),
        .row_sel   (row_sel),
        .out_valid (out_valid),
        .overrun   (overrun)
    );

    cim_weight_array #(
        .ROWS  (ROWS),
        .ROW_W (ROW_W),
        .AW    (AW)
    ) u_array (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (cur_row),
        .rd_data (rd_data),
        .wr_en   (cmp_en && op_q.wr_en),
        .wr_addr (op_q.wr_row),
        .wr_data (op_q.wr_data)
    );

    cim_mac_tree #(
        .LANES (LANES),
        .ACT_W (ACT_W)
    ) u_tree (
        .clk     (clk),
        .rst     (rst),
        .lat_en  (lat_en),
        .row_in  (rd_data),
        .sum_en  (cmp_en),
        .act_vec (op_q.act),
        .prec    (op_q.prec),
        .sum_q   (sum_out)
    );

endmodule

// File: rtl/cim_rcw_bank_chk.sv
module cim_rcw_bank_chk #(
    parameter int unsigned ROWS  = 8,
    parameter int unsigned SUM_W = 21
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    ovr_clr,
    input logic                    busy,
    input logic [ROWS-1:0]         row_sel,
    input logic signed [SUM_W-1:0] sum_out,
    input logic                    out_valid,
    input logic                    overrun
);

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !out_valid && !overrun && row_sel == '0 && sum_out == '0));

    p_busy_second_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    p_busy_ends_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |=> !busy);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(busy) && !busy));

    p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    p_sum_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(sum_out));

    p_rowsel_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones(row_sel) == 1));

    p_rowsel_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (row_sel == '0));

    p_rowsel_held_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(row_sel));

    p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> overrun);

    p_overrun_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);

    p_overrun_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (ovr_clr && !(start && busy)) |=> !overrun);

endmodule

bind cim_rcw_bank cim_rcw_bank_chk #(
    .ROWS  (ROWS),
    .SUM_W (SUM_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ovr_clr   (ovr_clr),
    .busy      (busy),
    .row_sel   (row_sel),
    .sum_out   (sum_out),
    .out_valid (out_valid),
    .overrun   (overrun)
);

// File: tb/cim_rcw_bank_bench.sv
module cim_rcw_bank_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          mode_i4;
    logic [2:0]    rd_row;
    logic [255:0]  act_vec;
    logic          wr_en;
    logic [2:0]    wr_row;
    logic [255:0]  wr_data;
    logic          ovr_clr;
    logic          busy;
    logic [7:0]    row_sel;
    logic signed [20:0] sum_out;
    logic          out_valid;
    logic          overrun;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [255:0] model [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    cim_rcw_bank u_cim_rcw_bank (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mode_i4   (mode_i4),
        .rd_row    (rd_row),
        .act_vec   (act_vec),
        .wr_en     (wr_en),
        .wr_row    (wr_row),
        .wr_data   (wr_data),
        .ovr_clr   (ovr_clr),
        .busy      (busy),
        .row_sel   (row_sel),
        .sum_out   (sum_out),
        .out_valid (out_valid),
        .overrun   (overrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint got, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic logic [255:0] pat(input int unsigned seed);
        logic [31:0]  x;
        logic [255:0] v;
        x = seed * 32'd2654435761 + 32'd7;
        for (int j = 0; j < 8; j++) begin
            x = x * 32'd1664525 + 32'd1013904223;
            v[j*32 +: 32] = x ^ {x[15:0], x[31:16]};
        end
        return v;
    endfunction

    function automatic logic [255:0] rep(input logic [7:0] b);
        return {32{b}};
    endfunction

    function automatic int exp_sum(input logic [255:0] row, input logic [255:0] act, input bit i4);
        int s;
        s = 0;
        for (int i = 0; i < 32; i++) begin
            int w;
            int a;
            if (i4) w = $signed(row[i*4 +: 4]);
            else    w = $signed(row[i*8 +: 8]);
            a = $signed(act[i*8 +: 8]);
            s += w * a;
        end
        return s;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One full operation with timing, row select and result checks.
    task automatic run_op(input int rd, input logic [255:0] act, input bit i4,
                          input bit we, input int wr, input logic [255:0] wd,
                          input string req);
        int exp;
        exp = exp_sum(model[rd], act, i4);
        @(negedge clk);
        start = 1'b1; rd_row = 3'(rd); act_vec = act; mode_i4 = i4;
        wr_en = we; wr_row = 3'(wr); wr_data = wd;
        @(negedge clk);
        start = 1'b0;
        act_vec = ~act; wr_data = ~wd; mode_i4 = ~i4;
        chk(busy && !out_valid, "R2", "phase1 busy", busy, 1);
        chk(row_sel == 8'(1 << rd), "R7", "phase1 row_sel", row_sel, 1 << rd);
        @(negedge clk);
        chk(busy && !out_valid, "R2", "phase2 busy", busy, 1);
        chk(row_sel == 8'(1 << rd), "R7", "phase2 row_sel", row_sel, 1 << rd);
        @(negedge clk);
        chk(!busy && out_valid, "R2", "result valid", out_valid, 1);
        chk(row_sel == 8'd0, "R7", "idle row_sel", row_sel, 0);
        chk(int'(sum_out) == exp, req, "sum", int'(sum_out), exp);
        if (we) model[wr] = wd;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; mode_i4 = 1'b0; rd_row = '0; act_vec = '0;
        wr_en = 1'b0; wr_row = '0; wr_data = '0; ovr_clr = 1'b0;
        for (int r = 0; r < 8; r++) model[r] = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !out_valid && !overrun && row_sel == 0 && sum_out == 0,
            "R1", "state in reset", {busy, out_valid, overrun}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !out_valid && !overrun && row_sel == 0 && sum_out == 0,
            "R1", "state after reset", {busy, out_valid, overrun}, 0);

        // R10 / R6: every row reads zero; the same row is rewritten in phase two
        for (int r = 0; r < 8; r++) begin
            run_op(r, pat(50 + r), 1'b0, 1'b1, r, pat(100 + r), "R10");
        end

        // R3: INT8 sweep over all rows, several activation patterns
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 4; k++) begin
                run_op(r, pat(200 + r*7 + k), 1'b0, 1'b0, 0, '0, "R3");
            end
        end

        // R4: INT4 sweep; upper half of each row holds unrelated data
        for (int r = 0; r < 8; r++) begin
            for (int k = 0; k < 4; k++) begin
                run_op(r, pat(400 + r*5 + k), 1'b1, 1'b0, 0, '0, "R4");
            end
        end

        // R3: range extremes
        run_op(1, '0, 1'b0, 1'b1, 0, rep(8'h80), "R5");
        run_op(0, rep(8'h80), 1'b0, 1'b0, 0, '0, "R3");
        chk(int'(sum_out) == 524288, "R3", "max positive", int'(sum_out), 524288);
        run_op(0, rep(8'h7F), 1'b0, 1'b0, 0, '0, "R3");
        chk(int'(sum_out) == -520192, "R3", "max negative", int'(sum_out), -520192);

        // R4: nibble order, lanes 0 and 1 only
        run_op(1, '0, 1'b0, 1'b1, 2, {248'd0, 8'h3A}, "R5");
        run_op(2, {240'd0, 8'd1, 8'd0}, 1'b1, 1'b0, 0, '0, "R4");
        chk(int'(sum_out) == 3, "R4", "upper nibble is lane 1", int'(sum_out), 3);
        run_op(2, {240'd0, 8'd0, 8'd1}, 1'b1, 1'b0, 0, '0, "R4");
        chk(int'(sum_out) == -6, "R4", "lower nibble is lane 0", int'(sum_out), -6);

        // R4: every 4-bit code against activation extremes
        for (int n = 0; n < 16; n++) begin
            run_op(3, '0, 1'b0, 1'b1, 2, {{16{8'h5C}}, {16{n[3:0], n[3:0]}}}, "R5");
            run_op(2, rep(8'h80), 1'b1, 1'b0, 0, '0, "R4");
            run_op(2, rep(8'h7F), 1'b1, 1'b0, 0, '0, "R4");
            run_op(2, rep(8'hFF), 1'b1, 1'b0, 0, '0, "R4");
            run_op(2, pat(600 + n), 1'b1, 1'b0, 0, '0, "R4");
        end

        // R6: same-row write uses the old contents; R5: new data next time
        run_op(4, pat(700), 1'b0, 1'b1, 4, pat(701), "R6");
        run_op(4, pat(700), 1'b0, 1'b0, 0, '0, "R5");
        run_op(5, pat(702), 1'b1, 1'b1, 6, pat(703), "R5");
        run_op(6, pat(704), 1'b1, 1'b0, 0, '0, "R5");

        // R2: sum holds while idle
        begin
            logic signed [20:0] held;
            held = sum_out;
            repeat (3) @(negedge clk);
            chk(sum_out == held && !out_valid, "R2", "sum held", int'(sum_out), int'(held));
        end

        // R8: a start during phase one is dropped
        begin
            int expa;
            expa = exp_sum(model[1], pat(800), 1'b0);
            @(negedge clk);
            start = 1'b1; rd_row = 3'd1; act_vec = pat(800); mode_i4 = 1'b0; wr_en = 1'b0;
            @(negedge clk);
            rd_row = 3'd2; act_vec = pat(801); mode_i4 = 1'b1; wr_en = 1'b1;
            wr_row = 3'd1; wr_data = pat(802);
            @(negedge clk);
            start = 1'b0; wr_en = 1'b0;
            chk(overrun, "R8", "overrun set", overrun, 1);
            chk(row_sel == 8'h02, "R8", "row kept", row_sel, 2);
            @(negedge clk);
            chk(out_valid && int'(sum_out) == expa, "R8", "first result", int'(sum_out), expa);
            for (int c = 0; c < 3; c++) begin
                @(negedge clk);
                chk(!busy && !out_valid, "R8", "no second operation", {busy, out_valid}, 0);
            end
            run_op(1, pat(803), 1'b0, 1'b0, 0, '0, "R8");
        end

        // R9: sticky, clear, and set-over-clear
        chk(overrun, "R9", "still set after normal op", overrun, 1);
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk(!overrun, "R9", "cleared", overrun, 0);
        @(negedge clk);
        start = 1'b1; rd_row = 3'd3; act_vec = pat(900); mode_i4 = 1'b0;
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; ovr_clr = 1'b0;
        chk(overrun, "R9", "set wins over clear", overrun, 1);
        repeat (3) @(negedge clk);
        chk(overrun, "R9", "held idle", overrun, 1);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        chk(!overrun, "R9", "final clear", overrun, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule